// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause-22 management master. It runs register read and register write cycles on the two-wire MDC/MDIO serial link to an external Ethernet PHY. Software drives it through four small registers on a write port: a configuration word, a command word, a combined PHY/register address word and a write-data word. Writing the write-data word starts a write frame to the stored address. Setting the read bit of the command word starts a read frame.

A 4-bit indicator output reports when the engine is busy and when read data is not yet valid. The 16-bit read-data output holds the last completed read. MDC is the system clock divided by a programmable even factor. It idles low and runs only while a frame is in flight. A management-reset bit in the configuration word aborts any frame and holds the engine idle for as long as it stays set.

Top module: `mdio_master`

## Requirements
- R1: After reset the indicator reads 0, `mdc` is low and `mdio_oe` is low. Whenever busy (indicator bit 0) is clear, `mdc` is low. Indicator bits 1 and 3 (link-fail) always read 0.
- R2: Register select 2 is the address word. Bits 4:0 carry the register address and bits 12:8 carry the PHY address. Bits 7:5 and 15:13 are ignored.
- R3: Writing register select 3 while idle sends a 64-bit frame, MSB first: 32 ones, start `01`, opcode `01`, PHY address, register address, turnaround `10`, then the 16 written data bits.
- R4: Writing register select 1 with bit 0 set while idle sends the read frame: 32 ones, `01`, opcode `10`, PHY address, register address. `mdio_oe` is high for frame bits 0..45 and low from bit 46 (turnaround) to the end. The 16 bits sampled in frame bits 48..63 form the read data, MSB first.
- R5: The configuration word (select 0) holds a half-period value H in bits 7:0. MDC has period 2*(H+1) system clocks. After reset H is 19, which divides by 40.
- R6: Busy is set on the clock edge that accepts a command. It clears on the falling MDC edge after the last frame bit. On a read, the read data is updated in that same cycle.
- R7: Indicator bit 2 (read data not valid) is set when a read starts and clears together with busy. A write frame leaves it at 0. It is never set while busy is clear.
- R8: A write-data write or a read command issued while busy is set is ignored. The running frame completes unchanged and no further frame follows.
- R9: A command word with bit 0 clear (for example only bit 1, the reserved scan bit) starts nothing.
- R10: Configuration bit 15 is the management reset. While it is set, any running frame is abandoned, busy and not-valid read 0, `mdc` is low and commands are ignored. Clearing it allows new frames.
- R11: `mdio_o` changes only while `mdc` is low. The master launches bits on falling MDC edges and samples `mdio_i` on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 command, 2 address, 3 write data |
| reg_wdata | input | 16 | Register write value |
| indicator | output | 4 | Bit 0 busy, bit 2 read-data-not-valid, bit 3 link-fail (0), bit 1 zero |
| read_data | output | 16 | Result of the last completed read |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Serial data seen on MDIO |

## Verification
The assertions assume that the register port is driven synchronously. They also assume that `mdio_i` changes only while MDC is low, so that it is stable at every rising MDC edge. The bench model of the PHY drives `mdio_i` only after a falling MDC edge, and it holds the line at 1 outside the read data phase. The bench also never changes the divider while a frame runs, because the MDC period check relies on a constant half-period. Every register write is applied on the falling system-clock edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_IDX     = FRAME_BITS - DATA_W - 2;
  localparam int DATA_IDX   = FRAME_BITS - DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int IND_W      = 4;

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_CMD   = 2'd1,
    SEL_ADDR  = 2'd2,
    SEL_WDATA = 2'd3
  } reg_sel_e;

  // Assemble the serial frame, first bit in the MSB.
  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic              is_read,
      input logic [PHY_W-1:0]  phy,
      input logic [REG_W-1:0]  rga,
      input logic [DATA_W-1:0] dat);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] body;
    op   = is_read ? 2'b10 : 2'b01;
    ta   = is_read ? 2'b00 : 2'b10;
    body = is_read ? '0 : dat;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, rga, ta, body};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half_i,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             at_half;

  assign at_half  = en && (cnt == half_i);
  assign rise_stb = at_half && !mdc;
  assign fall_stb = at_half && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_half) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: a level change of MDC while running happens only at the half-period count
  assert_toggle_at_half_R5: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (mdc != $past(mdc))) |-> ($past(cnt) == $past(half_i)));
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  logic              start_rd,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              run,
  output logic              nvalid,
  output logic              mdo,
  output logic              oe,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DAT_POS  = IDX_W'(DATA_IDX);

  logic                  rd_op;
  logic [FRAME_BITS-1:0] sr;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      idx_nx;
  logic [DATA_W-1:0]     cap;
  logic                  last_fall;

  assign mdo       = sr[FRAME_BITS-1];
  assign idx_nx    = idx + 1'b1;
  assign last_fall = run && fall_stb && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      run    <= 1'b0;
      rd_op  <= 1'b0;
      nvalid <= 1'b0;
      oe     <= 1'b0;
      idx    <= '0;
      sr     <= '0;
    end else if (!run) begin
      if (start) begin
        run    <= 1'b1;
        rd_op  <= start_rd;
        nvalid <= start_rd;
        oe     <= 1'b1;
        idx    <= '0;
        sr     <= build_frame(start_rd, phy_i, reg_i, wdata_i);
      end
    end else if (fall_stb) begin
      if (idx == LAST_IDX) begin
        run    <= 1'b0;
        oe     <= 1'b0;
        nvalid <= 1'b0;
      end else begin
        idx <= idx_nx;
        sr  <= {sr[FRAME_BITS-2:0], 1'b0};
        oe  <= !(rd_op && (idx_nx >= TA_POS));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap   <= '0;
      rdata <= '0;
    end else begin
      if (run && rise_stb && rd_op && (idx >= DAT_POS))
        cap <= {cap[DATA_W-2:0], mdio_i};
      if (last_fall && rd_op)
        rdata <= cap;
    end
  end

  // R11: the launched bit holds except on a falling MDC edge
  assert_mdo_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(fall_stb)) |-> $stable(mdo));
  // R8: the kind of a running frame never changes mid-frame
  assert_kind_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(rd_op));
  // R4: the master never drives during the read data phase
  assert_release_data_R4: assert property (@(posedge clk) disable iff (rst)
    (run && rd_op && rise_stb && (idx >= DAT_POS)) |-> !oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DEF_HALF = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [IND_W-1:0]  indicator,
  output logic [DATA_W-1:0] read_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int MGMT_RST_BIT = 15;
  localparam int PHY_LSB      = 8;

  logic             cfg_rst;
  logic [DIV_W-1:0] cfg_half;
  logic [PHY_W-1:0] phy_q;
  logic [REG_W-1:0] reg_q;
  logic             busy;
  logic             nvalid;
  logic             rise_stb;
  logic             fall_stb;
  logic             start_wr;
  logic             start_rd;
  logic             start_any;

  assign start_wr  = reg_we && (reg_sel == SEL_WDATA);
  assign start_rd  = reg_we && (reg_sel == SEL_CMD) && reg_wdata[0];
  assign start_any = (start_wr || start_rd) && !cfg_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rst  <= 1'b0;
      cfg_half <= DIV_W'(DEF_HALF);
      phy_q    <= '0;
      reg_q    <= '0;
    end else if (reg_we) begin
      if (reg_sel == SEL_CFG) begin
        cfg_rst  <= reg_wdata[MGMT_RST_BIT];
        cfg_half <= reg_wdata[DIV_W-1:0];
      end
      if (reg_sel == SEL_ADDR) begin
        reg_q <= reg_wdata[REG_W-1:0];
        phy_q <= reg_wdata[PHY_LSB +: PHY_W];
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .en       (busy && !cfg_rst),
    .half_i   (cfg_half),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .abort    (cfg_rst),
    .start    (start_any),
    .start_rd (start_rd),
    .phy_i    (phy_q),
    .reg_i    (reg_q),
    .wdata_i  (reg_wdata[DATA_W-1:0]),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .run      (busy),
    .nvalid   (nvalid),
    .mdo      (mdio_o),
    .oe       (mdio_oe),
    .rdata    (read_data)
  );

  assign indicator = {1'b0, nvalid, 1'b0, busy};

  // R1: MDC rests low whenever the engine is idle
  assert_idle_mdc_low_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R7: not-valid only while a frame is in flight
  assert_nvalid_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    nvalid |-> busy);
  // R6: an accepted command shows busy on the next edge
  assert_busy_prompt_R6: assert property (@(posedge clk) disable iff (rst)
    (start_any && !busy) |=> busy);
  // R10: management reset keeps the engine idle
  assert_mgmt_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rst) |-> (!busy && !nvalid));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [3:0]  indicator;
  logic [15:0] read_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, per = 0, k = 0, r11_err = 0;
  logic [63:0] cap = 0, oecap = 0;
  logic [15:0] resp = 0;
  logic        prev_mdo = 0;

  always #2.5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .indicator(indicator), .read_data(read_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    k++;
    per = cyc - last_rise;
    last_rise = cyc;
  end

  always @(negedge mdc) mdio_i = (k >= 48 && k <= 63) ? resp[63-k] : 1'b1;

  always @(negedge clk) begin
    if (!rst && (mdio_o !== prev_mdo) && mdc) r11_err++;
    prev_mdo = mdio_o;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && indicator[0]; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] wframe(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d, input int half);
    wr(2, {3'b111, p, 3'b101, r});
    k = 0;
    wr(3, d);
    check("R6 busy after write cmd", indicator[0], 1);
    check("R7 nvalid clear on write", indicator[2], 0);
    wait_idle();
    check("R3/R2 write frame", cap, wframe(p, r, d));
    check("R3 oe high whole write", oecap, {64{1'b1}});
    check("R5 mdc period", per, 2 * (half + 1));
    check("R1 mdc low when idle", mdc, 0);
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [45:0] hdr;
    hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    wr(2, {3'b000, p, 3'b000, r});
    k = 0; resp = d;
    wr(1, 16'h0001);
    check("R6 busy after read cmd", indicator[0], 1);
    check("R7 nvalid set on read", indicator[2], 1);
    wait_idle();
    check("R6/R7 nvalid clears with busy", indicator[2], 0);
    check("R4/R6 read data at busy clear", read_data, d);
    check("R4/R2 read header", cap[63:18], hdr);
    check("R4 oe release from bit 46", oecap, {{46{1'b1}}, 18'h0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset indicator", indicator, 0);
    check("R1 reset mdc", mdc, 0);
    check("R1 reset oe", mdio_oe, 0);

    // default divider 40
    do_write(5'h11, 5'h0A, 16'hBEEF, 19);

    wr(0, 16'h0001);
    for (int i = 0; i < 6; i++)
      do_write(5'(i * 7 + 1), 5'(31 - i * 5), 16'(16'h1357 * (i + 3) ^ (i << 12)), 1);
    for (int i = 0; i < 6; i++)
      do_read(5'(i * 5 + 2), 5'(i * 3), 16'(16'hA5C3 * (i + 1) + i));

    wr(0, 16'h0003);
    do_write(5'h1F, 5'h1F, 16'h8001, 3);
    do_read(5'h00, 5'h01, 16'h7FFE);
    wr(0, 16'h0001);

    // R8: commands while busy are ignored
    wr(2, {3'b0, 5'h03, 3'b0, 5'h04});
    k = 0; resp = 16'h1234;
    wr(1, 16'h0001);
    repeat (10) @(negedge clk);
    wr(3, 16'hFFFF);
    wr(1, 16'h0001);
    wait_idle();
    check("R8 frame unchanged", cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h04});
    check("R8 read data of first frame", read_data, 16'h1234);
    repeat (20) @(negedge clk);
    check("R8 no extra frame busy", indicator[0], 0);
    check("R8 no extra mdc edges", k, 64);

    // R9: scan bit alone starts nothing
    k = 0;
    wr(1, 16'h0002);
    check("R9 no busy on bit1", indicator[0], 0);
    repeat (10) @(negedge clk);
    check("R9 no mdc edges", k, 0);

    // R10: management reset
    k = 0; resp = 16'h5555;
    wr(1, 16'h0001);
    repeat (30) @(negedge clk);
    wr(0, 16'h8001);
    @(negedge clk);
    check("R10 abort indicator", indicator, 0);
    check("R10 abort mdc", mdc, 0);
    wr(1, 16'h0001);
    wr(3, 16'h0F0F);
    repeat (5) @(negedge clk);
    check("R10 commands ignored in reset", indicator[0], 0);
    wr(0, 16'h0001);
    do_read(5'h09, 5'h12, 16'hC0DE);

    check("R11 mdio only changes while mdc low", r11_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule